// File: doc/BRIEF.md
# Half-Precision Result Formatter

This block sits at the write-back end of a packed half-precision datapath. It takes the two 16-bit lane results, the current value of the destination word and a 2-bit format code. From these it builds the 32-bit word to be written, together with a pair of per-half write enables.

Four modes are supported. The first packs both lanes side by side. The second widens lane 0 to single precision. The last two replace one 16-bit half of the destination with one lane and keep the other half as it was. The widening path is exact and needs no rounding. It does zero half-precision subnormals before conversion, keeping their sign.

The result is computed combinationally. By default it is captured in an output register, so a result appears one clock after its inputs. The register can be removed with a parameter.

Top module: `hpf_formatter`

## Requirements
- R1: With format code 0 (packed pair), the output word is lane 1 in bits 31:16 and lane 0 in bits 15:0, and the write-enable pair is 2'b11.
- R2: With format code 1 (single-precision output), a normal lane-0 value is widened exactly. The sign is kept, the exponent is rebiased from 15 to 127, and the 10-bit mantissa is placed in bits 22:13 with zeros below it. The write-enable pair is 2'b11, and lane 1 has no effect on the output.
- R3: With format code 1, a lane-0 value with exponent field 0 and a non-zero mantissa (a subnormal) produces 32'h0000_0000 or 32'h8000_0000, following the lane-0 sign bit.
- R4: With format code 1, a lane-0 infinity (exponent 31, mantissa 0) produces a single-precision infinity of the same sign.
- R5: With format code 1, a lane-0 NaN produces a NaN with exponent 8'hFF, quiet bit 22 set and the 9 low payload bits placed in bits 21:13. This holds for both quiet and signalling inputs.
- R6: With format code 2 (low merge), the output is old-destination bits 31:16 above lane 0, and the write-enable pair is 2'b01. Lane 1 has no effect.
- R7: With format code 3 (high merge), the output is lane 1 above old-destination bits 15:0, and the write-enable pair is 2'b10. Lane 0 has no effect.
- R8: With format code 1, a signed zero on lane 0 widens to a single-precision zero of the same sign.
- R9: With the output register enabled (default), results appear one clock after their inputs. While reset is asserted, the output word is 0 and the write-enable pair is 2'b00. After reset, the write-enable pair is never 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt | input | 2 | Format code: 0 packed, 1 single precision, 2 low merge, 3 high merge |
| lane0 | input | 16 | Lane 0 half-precision result |
| lane1 | input | 16 | Lane 1 half-precision result |
| old_dst | input | 32 | Current destination word, used by the merge modes |
| dst_out | output | 32 | Formatted destination word |
| wr_en | output | 2 | Write enables; bit 1 covers bits 31:16, bit 0 covers bits 15:0 |

## Verification
The widening path is exercised with lane-0 values at each class boundary: the smallest and largest normals, subnormals of both signs, both zeros, both infinities, and quiet and signalling NaNs. These vectors separate a correct rebias from an off-by-one bias, a flush from a pass-through, and a forced quiet bit from a copied one.

Packed and merge modes are driven with distinct, asymmetric patterns in the two lanes and in the old word. This exposes swapped halves and a wrong half kept. The unused lane or half is varied between back-to-back vectors to show that it has no effect.

A long run of random codes and operands is then compared on every clock against a behavioural model that carries the one-cycle latency.

// File: rtl/hpf_pkg.sv
package hpf_pkg;
    localparam int HW    = 16;
    localparam int WW    = 32;
    localparam int HE    = 5;
    localparam int HM    = 10;
    localparam int SE    = 8;
    localparam int SM    = 23;
    localparam int HBIAS = 15;
    localparam int SBIAS = 127;

    typedef enum logic [1:0] {
        FMT_PAIR   = 2'd0,
        FMT_WIDE   = 2'd1,
        FMT_MRG_LO = 2'd2,
        FMT_MRG_HI = 2'd3
    } fmt_e;

    typedef struct packed {
        logic [WW-1:0] word;
        logic [1:0]    we;
    } fmt_result_t;
endpackage

// File: rtl/hpf_widen.sv
module hpf_widen
    import hpf_pkg::*;
(
    input  logic [HW-1:0] half_in,
    output logic [WW-1:0] single_out
);
    localparam int MSHIFT = SM - HM;
    localparam int BDIFF  = SBIAS - HBIAS;

    logic          sgn;
    logic [HE-1:0] hexp;
    logic [HM-1:0] hman;

    assign sgn  = half_in[HW-1];
    assign hexp = half_in[HW-2 -: HE];
    assign hman = half_in[HM-1:0];

    always_comb begin
        if (hexp == '0) begin
            // zero and subnormal both become signed zero
            single_out = {sgn, {(WW-1){1'b0}}};
        end else if (hexp == '1) begin
            if (hman == '0)
                single_out = {sgn, {SE{1'b1}}, {SM{1'b0}}};
            else
                single_out = {sgn, {SE{1'b1}}, 1'b1, hman[HM-2:0], {MSHIFT{1'b0}}};
        end else begin
            single_out = {sgn, SE'(hexp) + SE'(BDIFF), hman, {MSHIFT{1'b0}}};
        end
    end
endmodule

// File: rtl/hpf_mux.sv
module hpf_mux
    import hpf_pkg::*;
(
    input  fmt_e          mode,
    input  logic [HW-1:0] lo_lane,
    input  logic [HW-1:0] hi_lane,
    input  logic [WW-1:0] prev_word,
    input  logic [WW-1:0] wide_word,
    output fmt_result_t   res
);
    always_comb begin
        unique case (mode)
            FMT_PAIR: begin
                res.word = {hi_lane, lo_lane};
                res.we   = 2'b11;
            end
            FMT_WIDE: begin
                res.word = wide_word;
                res.we   = 2'b11;
            end
            FMT_MRG_LO: begin
                res.word = {prev_word[WW-1:HW], lo_lane};
                res.we   = 2'b01;
            end
            FMT_MRG_HI: begin
                res.word = {hi_lane, prev_word[HW-1:0]};
                res.we   = 2'b10;
            end
            default: begin
                res.word = {hi_lane, lo_lane};
                res.we   = 2'b11;
            end
        endcase
    end
endmodule

// File: rtl/hpf_formatter.sv
module hpf_formatter
    import hpf_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    fmt,
    input  logic [HW-1:0] lane0,
    input  logic [HW-1:0] lane1,
    input  logic [WW-1:0] old_dst,
    output logic [WW-1:0] dst_out,
    output logic [1:0]    wr_en
);
    logic [WW-1:0] wide_w;
    fmt_result_t   comb_res;

    hpf_widen u_widen (
        .half_in    (lane0),
        .single_out (wide_w)
    );

    hpf_mux u_mux (
        .mode      (fmt_e'(fmt)),
        .lo_lane   (lane0),
        .hi_lane   (lane1),
        .prev_word (old_dst),
        .wide_word (wide_w),
        .res       (comb_res)
    );

    generate
        if (OUT_REG) begin : g_reg
            fmt_result_t res_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) res_q <= '0;
                else        res_q <= comb_res;
            end
            assign dst_out = res_q.word;
            assign wr_en   = res_q.we;
        end else begin : g_comb
            assign dst_out = comb_res.word;
            assign wr_en   = comb_res.we;
        end
    endgenerate
endmodule

// File: rtl/hpf_formatter_chk.sv
module hpf_formatter_chk
    import hpf_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    fmt,
    input logic [HW-1:0] lane0,
    input logic [HW-1:0] lane1,
    input logic [WW-1:0] old_dst,
    input logic [WW-1:0] dst_out,
    input logic [1:0]    wr_en
);
    generate
        if (OUT_REG) begin : g_seq
            assert_packed_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (fmt == 2'd0) |=> (dst_out == {$past(lane1), $past(lane0)}) && (wr_en == 2'b11));

            assert_subnorm_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (fmt == 2'd1 && lane0[14:10] == 5'd0) |=>
                    (dst_out[30:0] == 31'd0) && (dst_out[31] == $past(lane0[15])));

            assert_inf_exp_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (fmt == 2'd1 && lane0[14:10] == 5'h1F) |=> (dst_out[30:23] == 8'hFF));

            assert_nan_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (fmt == 2'd1 && lane0[14:10] == 5'h1F && lane0[9:0] != 10'd0) |=> dst_out[22]);

            assert_merge_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (fmt == 2'd2) |=> (dst_out == {$past(old_dst[31:16]), $past(lane0)}) && (wr_en == 2'b01));

            assert_merge_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (fmt == 2'd3) |=> (dst_out == {$past(lane1), $past(old_dst[15:0])}) && (wr_en == 2'b10));

            assert_we_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (wr_en != 2'b00));
        end else begin : g_comb
            always_comb begin
                if (fmt == 2'd0)
                    assert_packed_comb_R1: assert (dst_out == {lane1, lane0} && wr_en == 2'b11);
            end
        end
    endgenerate
endmodule

bind hpf_formatter hpf_formatter_chk #(.OUT_REG(OUT_REG)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .fmt     (fmt),
    .lane0   (lane0),
    .lane1   (lane1),
    .old_dst (old_dst),
    .dst_out (dst_out),
    .wr_en   (wr_en)
);

// File: tb/test_hpf_formatter.sv
module test_hpf_formatter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic [15:0] lane0 = '0;
    logic [15:0] lane1 = '0;
    logic [31:0] old_dst = '0;
    logic [31:0] dst_out;
    logic [1:0]  wr_en;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [33:0] exp_q = '0;
    string       tag_q = "";
    bit          have_exp = 1'b0;

    always #2 clk = ~clk;

    hpf_formatter i_hpf_formatter (
        .clk(clk), .rst_n(rst_n), .fmt(fmt), .lane0(lane0), .lane1(lane1),
        .old_dst(old_dst), .dst_out(dst_out), .wr_en(wr_en)
    );

    // behavioural reference: {we, word}
    function automatic logic [33:0] model(int f, int l0, int l1, longint od);
        longint w;
        int s, e, m;
        logic [1:0] we;
        s = (l0 >> 15) & 1;
        e = (l0 >> 10) & 31;
        m = l0 & 1023;
        case (f)
            0: begin w = (longint'(l1) << 16) + l0; we = 2'b11; end
            1: begin
                if (e == 0)       w = longint'(s) << 31;
                else if (e == 31) w = (longint'(s) << 31) + (longint'(255) << 23)
                                      + ((m == 0) ? 0 : ((longint'(1) << 22) + (longint'(m & 511) << 13)));
                else              w = (longint'(s) << 31) + (longint'(e - 15 + 127) << 23) + (longint'(m) << 13);
                we = 2'b11;
            end
            2: begin w = ((od >> 16) << 16) + l0; we = 2'b01; end
            default: begin w = (longint'(l1) << 16) + (od & 65535); we = 2'b10; end
        endcase
        return {we, w[31:0]};
    endfunction

    task automatic compare();
        if (have_exp) begin
            checks++;
            if ({wr_en, dst_out} !== exp_q) begin
                failures++;
                $display("FAIL %s: actual we=%b word=%h expected we=%b word=%h",
                         tag_q, wr_en, dst_out, exp_q[33:32], exp_q[31:0]);
            end
        end
    endtask

    // drive at negedge, result checked at the following negedge (one register)
    task automatic step(input logic [1:0] f, input logic [15:0] a, input logic [15:0] b,
                        input logic [31:0] od, input string tag);
        @(negedge clk);
        compare();
        fmt = f; lane0 = a; lane1 = b; old_dst = od;
        exp_q = model(int'(f), int'(a), int'(b), longint'(od));
        tag_q = tag;
        have_exp = 1'b1;
    endtask

    task automatic expect_word(input logic [31:0] want, input string tag);
        checks++;
        if (dst_out !== want) begin
            failures++;
            $display("FAIL %s: actual %h expected %h", tag, dst_out, want);
        end
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                failures++;
                checks++;
                $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (dst_out !== 32'd0 || wr_en !== 2'b00) begin
            failures++;
            $display("FAIL R9 reset: actual we=%b word=%h expected we=00 word=0", wr_en, dst_out);
        end
        rst_n = 1'b1;

        step(2'd0, 16'hC000, 16'h3C00, 32'h0, "R1 packed a");
        step(2'd0, 16'h1234, 16'hABCD, 32'hFFFFFFFF, "R1 packed b");
        step(2'd1, 16'h3C00, 16'h1111, 32'h0, "R2 one");
        @(negedge clk); compare(); have_exp = 1'b0;
        expect_word(32'h3F800000, "R2 1.0 widened");
        step(2'd1, 16'h3C00, 16'hFFFF, 32'h0, "R2 lane1 ignored");
        step(2'd1, 16'hC500, 16'h0, 32'h0, "R2 -5.0");
        @(negedge clk); compare(); have_exp = 1'b0;
        expect_word(32'hC0A00000, "R2 -5.0 widened");
        step(2'd1, 16'h0400, 16'h0, 32'h0, "R2 min normal");
        step(2'd1, 16'h7BFF, 16'h0, 32'h0, "R2 max normal");
        @(negedge clk); compare(); have_exp = 1'b0;
        expect_word(32'h477FE000, "R2 max normal widened");
        step(2'd1, 16'h0001, 16'h0, 32'h0, "R3 pos subnormal");
        step(2'd1, 16'h83FF, 16'h0, 32'h0, "R3 neg subnormal");
        @(negedge clk); compare(); have_exp = 1'b0;
        expect_word(32'h80000000, "R3 neg subnormal flushed");
        step(2'd1, 16'h7C00, 16'h0, 32'h0, "R4 +inf");
        step(2'd1, 16'hFC00, 16'h0, 32'h0, "R4 -inf");
        @(negedge clk); compare(); have_exp = 1'b0;
        expect_word(32'hFF800000, "R4 -inf widened");
        step(2'd1, 16'h7E01, 16'h0, 32'h0, "R5 quiet nan");
        step(2'd1, 16'h7C01, 16'h0, 32'h0, "R5 signalling nan");
        @(negedge clk); compare(); have_exp = 1'b0;
        expect_word(32'h7FC02000, "R5 signalling nan quieted");
        step(2'd1, 16'h0000, 16'h0, 32'h0, "R8 +zero");
        step(2'd1, 16'h8000, 16'h0, 32'h0, "R8 -zero");
        @(negedge clk); compare(); have_exp = 1'b0;
        expect_word(32'h80000000, "R8 -zero widened");
        step(2'd2, 16'h1234, 16'h5678, 32'hDEADBEEF, "R6 merge low");
        @(negedge clk); compare(); have_exp = 1'b0;
        expect_word(32'hDEAD1234, "R6 merge low word");
        step(2'd2, 16'h1234, 16'hAAAA, 32'hDEADBEEF, "R6 lane1 ignored");
        step(2'd3, 16'h1234, 16'h5678, 32'hDEADBEEF, "R7 merge high");
        @(negedge clk); compare(); have_exp = 1'b0;
        expect_word(32'h5678BEEF, "R7 merge high word");
        step(2'd3, 16'h5555, 16'h5678, 32'hDEADBEEF, "R7 lane0 ignored");

        for (int i = 0; i < 2000; i++) begin
            step(2'($urandom), 16'($urandom), 16'($urandom), 32'($urandom), "R9 random latency");
        end
        @(negedge clk); compare();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule